// File: doc/BRIEF.md
# Write Protection Boundary Controller

This block guards a word-addressed nonvolatile array against unwanted writes. It holds a boundary register, a protection flag, a one-time lock bit and a write-enable latch. A serial command front end passes it decoded commands as a valid strobe, an opcode and an address. The block also samples two pin-level enables: the protect-access pin and the write pin.

For each write the front end wants to run, the block answers combinationally whether that write may go ahead. A write can be a single word, a burst of up to four words inside an aligned page, or a fill of the whole array. The block also builds the serial frame that a boundary-read command returns, and pulses a start strobe when a protection change begins its programming cycle.

The protected area is every address at or above the boundary, and only while the flag is 0. Changing the boundary, clearing it or locking it needs two things: an arming command given immediately before, and both pins high. Once the lock bit is set, the boundary and flag can no longer change.

Top module: `prot_guard`

## Requirements
- R1: After reset the boundary is all ones, the flag is 1, the lock is 0 and the write-enable latch is off. A boundary read then returns the 10-bit frame 0x1FF, and no write is granted.
- R2: Opcode 4 sets the write-enable latch and opcode 5 clears it. A write is granted only while the latch is set and we_pin_i is high.
- R3: The arming command (opcode 9) takes effect only when the latch is set and pre_i and we_pin_i are both high. Any other command that follows it drops the arming.
- R4: A boundary write (opcode 7) with address A, once armed, loads A and clears the flag. A single write (kind 1) is then refused for addresses of A or above and granted below A.
- R5: A boundary clear (opcode 8), once armed, sets the boundary to all ones and the flag to 1.
- R6: Opcodes 7, 8 and 10 are ignored unless the arming command came immediately before them and pre_i and we_pin_i are both high.
- R7: A boundary read (opcode 6) with pre_i high makes prrd_valid_o high for one cycle after the command edge. The frame is {0, boundary, flag}, sent MSB first. With pre_i low there is no response.
- R8: An armed lock command (opcode 10) sets the lock. After that, boundary writes and clears change nothing and give no start pulse.
- R9: prog_start_o pulses for one cycle after the edge at which an armed opcode 7, 8 or 10 executes.
- R10: A whole-array write (kind 3) is granted only while the flag is 1.
- R11: A page write (kind 2) of N words starts at wq_addr_i. Its low two address bits wrap, and the upper bits stay fixed. It is refused if any of its words is protected, or if N is 0 or greater than 4.
- R12: The arming command leaves the boundary and the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Command code: 0 read, 1 write, 2 page, 3 fill, 4 enable, 5 disable, 6 boundary read, 7 boundary write, 8 boundary clear, 9 arm, 10 lock |
| cmd_addr_i | input | 8 | Command address |
| pre_i | input | 1 | Protect-access pin |
| we_pin_i | input | 1 | Write pin |
| wq_kind_i | input | 2 | Write query kind: 0 none, 1 single, 2 page, 3 whole array |
| wq_addr_i | input | 8 | Write query start address |
| wq_cnt_i | input | 3 | Page word count |
| wq_grant_o | output | 1 | Write query granted |
| prog_start_o | output | 1 | Protection programming cycle start pulse |
| prrd_valid_o | output | 1 | Boundary read frame valid |
| prrd_frame_o | output | 10 | Boundary read frame, MSB first |

## Verification
Command effects are registered. A command given at one edge shows in the state, prog_start_o and prrd_valid_o in the cycle after that edge. The bench drives each command at a falling edge and latches the outputs at the next falling edge, so the sample falls exactly in that cycle. The grant is combinational from the state and the query inputs, so it is sampled 1 ns after the query inputs change, with no command pending.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [3:0] {
    CMD_READ    = 4'd0,
    CMD_WRITE   = 4'd1,
    CMD_PAGE    = 4'd2,
    CMD_FILL    = 4'd3,
    CMD_WEN     = 4'd4,
    CMD_WDS     = 4'd5,
    CMD_BRD     = 4'd6,
    CMD_BWR     = 4'd7,
    CMD_BCLR    = 4'd8,
    CMD_ARM     = 4'd9,
    CMD_LOCK    = 4'd10
  } cmd_e;

  typedef enum logic [1:0] {
    WQ_NONE   = 2'd0,
    WQ_SINGLE = 2'd1,
    WQ_PAGE   = 2'd2,
    WQ_ALL    = 2'd3
  } wq_e;
endpackage

// File: rtl/prot_cmd_seq.sv
module prot_cmd_seq
  import prot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_op_i,
  input  logic       pre_i,
  input  logic       we_pin_i,
  input  logic       lock_i,
  output logic       wen_o,
  output logic       bwr_en_o,
  output logic       bclr_en_o,
  output logic       lock_en_o,
  output logic       brd_en_o
);
  logic wen_q, armed_q;
  logic pins_ok, guarded;

  assign pins_ok = pre_i & we_pin_i;
  // protection changes need arming on the previous command and an unlocked register
  assign guarded = cmd_valid_i & armed_q & pins_ok & ~lock_i;

  assign bwr_en_o  = guarded & (cmd_op_i == CMD_BWR);
  assign bclr_en_o = guarded & (cmd_op_i == CMD_BCLR);
  assign lock_en_o = guarded & (cmd_op_i == CMD_LOCK);
  assign brd_en_o  = cmd_valid_i & pre_i & (cmd_op_i == CMD_BRD);
  assign wen_o     = wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (cmd_valid_i) begin
      armed_q <= (cmd_op_i == CMD_ARM) & wen_q & pins_ok;
      if (cmd_op_i == CMD_WEN)      wen_q <= 1'b1;
      else if (cmd_op_i == CMD_WDS) wen_q <= 1'b0;
    end
  end

  AST_EXEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bwr_en_o, bclr_en_o, lock_en_o})); // R6
  AST_ARM_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i != CMD_ARM) |=> !armed_q); // R3
  AST_ARM_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(wen_q)); // R3
endmodule

// File: rtl/prot_regs.sv
module prot_regs #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bwr_en_i,
  input  logic          bclr_en_i,
  input  logic          lock_en_i,
  input  logic          brd_en_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] bound_o,
  output logic          flag_o,
  output logic          lock_o,
  output logic          prog_start_o,
  output logic          prrd_valid_o,
  output logic [AW+1:0] prrd_frame_o
);
  logic [AW-1:0] bound_q;
  logic          flag_q, lock_q, start_q, rdv_q;
  logic [AW+1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bound_q <= '1;
      flag_q  <= 1'b1;
      lock_q  <= 1'b0;
      start_q <= 1'b0;
      rdv_q   <= 1'b0;
      frame_q <= '0;
    end else begin
      start_q <= bwr_en_i | bclr_en_i | lock_en_i;
      rdv_q   <= brd_en_i;
      if (brd_en_i) frame_q <= {1'b0, bound_q, flag_q};
      if (bwr_en_i) begin
        bound_q <= addr_i;
        flag_q  <= 1'b0;
      end else if (bclr_en_i) begin
        bound_q <= '1;
        flag_q  <= 1'b1;
      end
      if (lock_en_i) lock_q <= 1'b1;
    end
  end

  assign bound_o      = bound_q;
  assign flag_o       = flag_q;
  assign lock_o       = lock_q;
  assign prog_start_o = start_q;
  assign prrd_valid_o = rdv_q;
  assign prrd_frame_o = frame_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R8
  AST_LOCKED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> ($stable(bound_q) && $stable(flag_q))); // R8
  AST_BWR_FLAG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bwr_en_i |=> (!flag_q && bound_q == $past(addr_i))); // R4
  AST_BCLR_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclr_en_i |=> (flag_q && (&bound_q))); // R5
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q || $past(bwr_en_i | bclr_en_i | lock_en_i)); // R9
endmodule

// File: rtl/prot_wr_check.sv
module prot_wr_check
  import prot_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned PAGE_WORDS = 4,
  localparam int unsigned PW        = $clog2(PAGE_WORDS),
  localparam int unsigned CW        = $clog2(PAGE_WORDS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bound_i,
  input  logic          flag_i,
  input  logic          wen_i,
  input  logic          we_pin_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  output logic          grant_o
);
  logic [PAGE_WORDS-1:0] hit;
  logic                  single_hit, cnt_ok, area_ok;

  assign single_hit = ~flag_i & (addr_i >= bound_i);

  for (genvar k = 0; k < PAGE_WORDS; k++) begin : g_word
    logic [AW-1:0] a_k;
    // low bits wrap inside the page, upper bits held
    assign a_k    = {addr_i[AW-1:PW], addr_i[PW-1:0] + PW'(k)};
    assign hit[k] = (CW'(k) < cnt_i) & ~flag_i & (a_k >= bound_i);
  end

  assign cnt_ok = (cnt_i != '0) && (cnt_i <= CW'(PAGE_WORDS));

  always_comb begin
    unique case (kind_i)
      WQ_SINGLE: area_ok = ~single_hit;
      WQ_PAGE:   area_ok = cnt_ok & ~(|hit);
      WQ_ALL:    area_ok = flag_i;
      default:   area_ok = 1'b0;
    endcase
  end

  assign grant_o = wen_i & we_pin_i & area_ok;

  AST_ALL_NEEDS_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && kind_i == WQ_ALL) |-> flag_i); // R10
  AST_GRANT_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (wen_i && we_pin_i)); // R2
  AST_PAGE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && kind_i == WQ_PAGE) |-> (cnt_i != '0)); // R11
endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned PAGE_WORDS = 4,
  localparam int unsigned CW        = $clog2(PAGE_WORDS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [3:0]    cmd_op_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic          pre_i,
  input  logic          we_pin_i,
  input  logic [1:0]    wq_kind_i,
  input  logic [AW-1:0] wq_addr_i,
  input  logic [CW-1:0] wq_cnt_i,
  output logic          wq_grant_o,
  output logic          prog_start_o,
  output logic          prrd_valid_o,
  output logic [AW+1:0] prrd_frame_o
);
  logic          wen, bwr_en, bclr_en, lock_en, brd_en;
  logic [AW-1:0] bound;
  logic          flag, lock;

  prot_cmd_seq u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .pre_i, .we_pin_i,
    .lock_i    (lock),
    .wen_o     (wen),
    .bwr_en_o  (bwr_en),
    .bclr_en_o (bclr_en),
    .lock_en_o (lock_en),
    .brd_en_o  (brd_en)
  );

  prot_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .bwr_en_i     (bwr_en),
    .bclr_en_i    (bclr_en),
    .lock_en_i    (lock_en),
    .brd_en_i     (brd_en),
    .addr_i       (cmd_addr_i),
    .bound_o      (bound),
    .flag_o       (flag),
    .lock_o       (lock),
    .prog_start_o,
    .prrd_valid_o,
    .prrd_frame_o
  );

  prot_wr_check #(.AW(AW), .PAGE_WORDS(PAGE_WORDS)) u_chk (
    .clk_i, .rst_ni,
    .bound_i  (bound),
    .flag_i   (flag),
    .wen_i    (wen),
    .we_pin_i,
    .kind_i   (wq_kind_i),
    .addr_i   (wq_addr_i),
    .cnt_i    (wq_cnt_i),
    .grant_o  (wq_grant_o)
  );

  AST_PRRD_NEEDS_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prrd_valid_o |-> $past(cmd_valid_i && pre_i && cmd_op_i == CMD_BRD)); // R7
  AST_START_NOT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |-> !$past(lock)); // R8
endmodule

// File: tb/sim_prot_guard.sv
module sim_prot_guard;
  import prot_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0;
  logic       pre = 1'b0, we_pin = 1'b0;
  logic [1:0] wq_kind = '0;
  logic [7:0] wq_addr = '0;
  logic [2:0] wq_cnt = '0;
  logic       grant, pstart, rdv;
  logic [9:0] frame;

  int tests = 0, fails = 0;
  bit done = 0;
  logic seen_start, seen_rdv;
  logic [9:0] seen_frame;

  always #2 clk = ~clk;

  prot_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .pre_i(pre), .we_pin_i(we_pin), .wq_kind_i(wq_kind),
    .wq_addr_i(wq_addr), .wq_cnt_i(wq_cnt), .wq_grant_o(grant),
    .prog_start_o(pstart), .prrd_valid_o(rdv), .prrd_frame_o(frame)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input cmd_e op, input logic [7:0] a, input logic p, input logic w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; pre = p; we_pin = w;
    @(negedge clk);
    seen_start = pstart; seen_rdv = rdv; seen_frame = frame;
    cmd_valid = 1'b0;
  endtask

  task automatic read_frame(input string req, input logic [9:0] exp);
    issue(CMD_BRD, 8'h00, 1'b1, 1'b0);
    chk(req, {31'd0, seen_rdv}, 32'd1);
    chk(req, {22'd0, seen_frame}, {22'd0, exp});
  endtask

  task automatic query(input string req, input wq_e k, input logic [7:0] a,
                       input logic [2:0] n, input logic w, input logic exp);
    @(negedge clk);
    wq_kind = k; wq_addr = a; wq_cnt = n; we_pin = w;
    #1;
    chk(req, {31'd0, grant}, {31'd0, exp});
  endtask

  task automatic t_reset;
    chk("R1 start idle", {30'd0, pstart, rdv}, 32'd0);
    read_frame("R1 reset frame", 10'h1FF);
    query("R1 no grant", WQ_SINGLE, 8'h00, 3'd1, 1'b1, 1'b0);
  endtask

  task automatic t_wen;
    issue(CMD_WEN, 8'h00, 1'b0, 1'b0);
    query("R2 granted", WQ_SINGLE, 8'h10, 3'd1, 1'b1, 1'b1);
    query("R2 pin low", WQ_SINGLE, 8'h10, 3'd1, 1'b0, 1'b0);
    issue(CMD_WDS, 8'h00, 1'b0, 1'b0);
    query("R2 after disable", WQ_SINGLE, 8'h10, 3'd1, 1'b1, 1'b0);
  endtask

  task automatic t_gate;
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);        // latch off
    issue(CMD_BWR, 8'h80, 1'b1, 1'b1);
    chk("R3 arm needs wen", {31'd0, seen_start}, 32'd0);
    issue(CMD_WEN, 8'h00, 1'b0, 1'b0);
    issue(CMD_ARM, 8'h00, 1'b0, 1'b1);        // pre low
    issue(CMD_BWR, 8'h80, 1'b1, 1'b1);
    chk("R3 arm needs pre", {31'd0, seen_start}, 32'd0);
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_READ, 8'h00, 1'b1, 1'b1);       // breaks the chain
    issue(CMD_BWR, 8'h80, 1'b1, 1'b1);
    chk("R3 not immediate", {31'd0, seen_start}, 32'd0);
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_BWR, 8'h80, 1'b1, 1'b0);        // w low
    chk("R6 pin low", {31'd0, seen_start}, 32'd0);
    issue(CMD_BCLR, 8'h00, 1'b1, 1'b1);       // unarmed
    chk("R6 unarmed", {31'd0, seen_start}, 32'd0);
    read_frame("R6 unchanged", 10'h1FF);
  endtask

  task automatic t_bwr;
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_BWR, 8'h80, 1'b1, 1'b1);
    chk("R9 start", {31'd0, seen_start}, 32'd1);
    @(negedge clk);
    chk("R9 one cycle", {31'd0, pstart}, 32'd0);
    read_frame("R4 frame", 10'h100);
    query("R4 below", WQ_SINGLE, 8'h7F, 3'd1, 1'b1, 1'b1);
    query("R4 at", WQ_SINGLE, 8'h80, 3'd1, 1'b1, 1'b0);
    query("R4 top", WQ_SINGLE, 8'hFF, 3'd1, 1'b1, 1'b0);
    query("R10 fill shut", WQ_ALL, 8'h00, 3'd1, 1'b1, 1'b0);
  endtask

  task automatic t_page;
    query("R11 full page", WQ_PAGE, 8'h7C, 3'd4, 1'b1, 1'b1);
    query("R11 wrap", WQ_PAGE, 8'h7F, 3'd2, 1'b1, 1'b1);
    query("R11 hit", WQ_PAGE, 8'h80, 3'd1, 1'b1, 1'b0);
    query("R11 zero", WQ_PAGE, 8'h7C, 3'd0, 1'b1, 1'b0);
    query("R11 five", WQ_PAGE, 8'h7C, 3'd5, 1'b1, 1'b0);
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_BWR, 8'h7D, 1'b1, 1'b1);
    query("R11 later word hit", WQ_PAGE, 8'h7C, 3'd2, 1'b1, 1'b0);
    query("R11 first ok", WQ_PAGE, 8'h7C, 3'd1, 1'b1, 1'b1);
  endtask

  task automatic t_arm_flag;
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    read_frame("R12 arm keeps flag", 10'h0FA);
  endtask

  task automatic t_clear;
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_BCLR, 8'h00, 1'b1, 1'b1);
    chk("R9 clear start", {31'd0, seen_start}, 32'd1);
    read_frame("R5 cleared", 10'h1FF);
    query("R10 fill open", WQ_ALL, 8'h00, 3'd1, 1'b1, 1'b1);
    query("R5 top ok", WQ_SINGLE, 8'hFF, 3'd1, 1'b1, 1'b1);
  endtask

  task automatic t_lock;
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_BWR, 8'h40, 1'b1, 1'b1);
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_LOCK, 8'h00, 1'b1, 1'b1);
    chk("R8 lock start", {31'd0, seen_start}, 32'd1);
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_BWR, 8'h20, 1'b1, 1'b1);
    chk("R8 no start", {31'd0, seen_start}, 32'd0);
    issue(CMD_ARM, 8'h00, 1'b1, 1'b1);
    issue(CMD_BCLR, 8'h00, 1'b1, 1'b1);
    chk("R8 clear no start", {31'd0, seen_start}, 32'd0);
    read_frame("R8 frozen", 10'h080);
  endtask

  task automatic t_brd_pre;
    issue(CMD_BRD, 8'h00, 1'b0, 1'b1);
    chk("R7 pre low", {31'd0, seen_rdv}, 32'd0);
    @(negedge clk);
    chk("R7 idle", {31'd0, rdv}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wen();
    t_gate();
    t_bwr();
    t_page();
    t_arm_flag();
    t_clear();
    t_lock();
    t_brd_pre();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule